// File: doc/BRIEF.md
# Channel Error-Interrupt Enable with Set/Clear Command Bytes

This block holds one enable bit per channel for error interrupts and changes it through two write-only command bytes on a 32-bit register bus. A byte written to the set lane turns on one channel's enable, and a byte written to the clear lane turns one off. Either byte can instead name every channel, or mark itself as a no-operation so that it is skipped. Software can therefore change single enable bits without a read-modify-write. Several independent commands can also travel in one word write.

The enable vector can also be written and read as a plain field at its own word address. It is presented on `irq_en` for the interrupt logic that follows. Commands and direct writes take effect on the clock edge that samples the write strobe, so the result shows on `irq_en` after that edge.

Command byte layout, with bit 7 as the most significant bit:
- bit 7: no-op flag.
- bit 6: all-channels flag.
- bits 5:4: reserved.
- bits 3:0: channel index.

With the default parameters the enable field sits in bits 15:0 of word address 0. The set command is byte lane 2 (bits 23:16) of word address 1, and the clear command is byte lane 3 (bits 31:24) of the same word.

Top module: `chirq_en_cmd`

## Requirements
- R1: After reset, `irq_en` is all zeros.
- R2: A set-lane byte with bit 7 = 0 and bit 6 = 0 sets the enable bit of the channel given in bits 3:0 and leaves every other bit unchanged.
- R3: A clear-lane byte with bit 7 = 0 and bit 6 = 0 clears the enable bit of the channel given in bits 3:0 and leaves every other bit unchanged.
- R4: A command byte with bit 7 = 1 changes nothing, whatever its other bits hold.
- R5: A command byte with bit 7 = 0 and bit 6 = 1 (byte value 64 to 127) sets every enable bit (set lane) or clears every enable bit (clear lane). Its channel field is ignored.
- R6: Bits 5:4 of a command byte have no effect on the result.
- R7: A read of the command word returns zero.
- R8: One word write may carry a set command and a clear command together. When both reach the same channel, the set is applied first and the clear after it, so the bit ends cleared.
- R9: A write to the enable word loads bits 7:0 from byte lane 0 and bits 15:8 from byte lane 1 (limited to the implemented channels). A read of that word returns the enable vector zero-extended.
- R10: Only byte lanes whose byte enable is 1 are acted on, and nothing changes while `bus_wr` is 0. The change shows on `irq_en` after the clock edge that samples the write.
- R11: A channel index at or above NUM_CH has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Word address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte enables, bit i for bits 8i+7:8i |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_en | output | NUM_CH | Current per-channel enable vector |

## Verification
The assertions take it that a write lasts one cycle and that its address, data and byte enables are stable while the strobe is high. They also take it that reset is held for at least one clock edge before the first write. The stimulus drives every bus input at the falling edge, keeps the strobe high for exactly one rising edge, and holds reset low over several edges at the start. The bench uses a twelve-channel configuration, so channel indices 12 to 15 exercise the out-of-range case.

// File: rtl/chirq_pkg.sv
package chirq_pkg;
    localparam int CMD_BYTE_W = 8;
    localparam int SKIP_BIT   = 7;  // no-op flag position
    localparam int BCAST_BIT  = 6;  // all-channels flag position
    localparam int CH_IDX_W   = 4;  // channel field bits 3:0
    localparam int BUS_W      = 32;
    localparam int LANES      = BUS_W / CMD_BYTE_W;
    localparam int FIELD_W    = 16; // direct-write field width
endpackage

// File: rtl/chirq_cmd_dec.sv
module chirq_cmd_dec
    import chirq_pkg::*;
#(
    parameter int NUM_CH = 16
) (
    input  logic                  valid,
    input  logic [CMD_BYTE_W-1:0] cmd,
    output logic [NUM_CH-1:0]     mask
);
    logic [CH_IDX_W-1:0] ch_idx;
    logic                in_range;

    assign ch_idx   = cmd[CH_IDX_W-1:0];
    assign in_range = (32'(ch_idx) < NUM_CH);

    always_comb begin
        mask = '0;
        if (valid && !cmd[SKIP_BIT]) begin
            if (cmd[BCAST_BIT]) begin
                mask = '1;
            end else if (in_range) begin
                mask = {{(NUM_CH-1){1'b0}}, 1'b1} << ch_idx;
            end
        end
    end
endmodule

// File: rtl/chirq_bus_dec.sv
module chirq_bus_dec
    import chirq_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int EN_ADDR  = 0,
    parameter int CMD_ADDR = 1,
    parameter int SET_LANE = 2,
    parameter int CLR_LANE = 3
) (
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANES-1:0]  be,
    output logic              set_vld,
    output logic              clr_vld,
    output logic [1:0]        dir_we,
    output logic              en_sel
);
    logic hit_en;
    logic hit_cmd;

    assign hit_en  = (addr == ADDR_W'(EN_ADDR));
    assign hit_cmd = (addr == ADDR_W'(CMD_ADDR));
    assign en_sel  = hit_en;
    assign set_vld = wr && hit_cmd && be[SET_LANE];
    assign clr_vld = wr && hit_cmd && be[CLR_LANE];

    for (genvar g = 0; g < 2; g++) begin : g_dir
        assign dir_we[g] = wr && hit_en && be[g];
    end
endmodule

// File: rtl/chirq_en_cmd.sv
module chirq_en_cmd
    import chirq_pkg::*;
#(
    parameter int NUM_CH   = 16,
    parameter int ADDR_W   = 4,
    parameter int EN_ADDR  = 0,
    parameter int CMD_ADDR = 1,
    parameter int SET_LANE = 2,
    parameter int CLR_LANE = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    input  logic [LANES-1:0]  bus_be,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic [NUM_CH-1:0] irq_en
);
    typedef struct packed {
        logic [NUM_CH-1:0] en;
    } state_t;

    state_t st_d, st_q;

    logic                  set_vld, clr_vld, en_sel;
    logic [1:0]            dir_we;
    logic [NUM_CH-1:0]     set_mask, clr_mask;
    logic [CMD_BYTE_W-1:0] lane_byte [2];
    logic                  lane_vld  [2];
    logic [NUM_CH-1:0]     lane_mask [2];

    chirq_bus_dec #(
        .ADDR_W  (ADDR_W),
        .EN_ADDR (EN_ADDR),
        .CMD_ADDR(CMD_ADDR),
        .SET_LANE(SET_LANE),
        .CLR_LANE(CLR_LANE)
    ) u_bus_dec (
        .wr     (bus_wr),
        .addr   (bus_addr),
        .be     (bus_be),
        .set_vld(set_vld),
        .clr_vld(clr_vld),
        .dir_we (dir_we),
        .en_sel (en_sel)
    );

    // index 0 = set lane, index 1 = clear lane
    assign lane_byte[0] = bus_wdata[SET_LANE*CMD_BYTE_W +: CMD_BYTE_W];
    assign lane_byte[1] = bus_wdata[CLR_LANE*CMD_BYTE_W +: CMD_BYTE_W];
    assign lane_vld[0]  = set_vld;
    assign lane_vld[1]  = clr_vld;

    for (genvar g = 0; g < 2; g++) begin : g_cmd
        chirq_cmd_dec #(.NUM_CH(NUM_CH)) u_cmd_dec (
            .valid(lane_vld[g]),
            .cmd  (lane_byte[g]),
            .mask (lane_mask[g])
        );
    end

    assign set_mask = lane_mask[0];
    assign clr_mask = lane_mask[1];

    always_comb begin
        logic [FIELD_W-1:0] field;
        st_d  = st_q;
        field = FIELD_W'(st_q.en);
        if (|dir_we) begin
            for (int i = 0; i < 2; i++) begin
                if (dir_we[i]) field[i*8 +: 8] = bus_wdata[i*8 +: 8];
            end
            st_d.en = field[NUM_CH-1:0];
        end else begin
            // set first, then clear: clear wins on a shared channel
            st_d.en = (st_q.en | set_mask) & ~clr_mask;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_en    = st_q.en;
    assign bus_rdata = en_sel ? BUS_W'(st_q.en) : '0;

    p_reset_zero_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> (irq_en == '0));

    p_set_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (set_mask != '0 && clr_mask == '0)
        |=> ((irq_en & $past(set_mask)) == $past(set_mask)));

    p_clear_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_mask != '0) |=> ((irq_en & $past(clr_mask)) == '0));

    p_skip_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(CMD_ADDR)
         && bus_wdata[SET_LANE*8+SKIP_BIT] && bus_wdata[CLR_LANE*8+SKIP_BIT])
        |=> $stable(irq_en));

    p_cmd_reads_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(CMD_ADDR)) |-> (bus_rdata == '0));

    p_idle_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> $stable(irq_en));

    p_out_of_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(CMD_ADDR)
         && bus_be[SET_LANE] && !bus_be[CLR_LANE]
         && !bus_wdata[SET_LANE*8+SKIP_BIT] && !bus_wdata[SET_LANE*8+BCAST_BIT]
         && 32'(bus_wdata[SET_LANE*8 +: CH_IDX_W]) >= NUM_CH)
        |=> $stable(irq_en));
endmodule

// File: tb/chirq_en_cmd_tb.sv
module chirq_en_cmd_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NCH        = 12;
    localparam int AW         = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          bus_wr;
    logic [AW-1:0] bus_addr;
    logic [31:0]   bus_wdata;
    logic [3:0]    bus_be;
    logic [31:0]   bus_rdata;
    logic [NCH-1:0] irq_en;

    logic [NCH-1:0] model;
    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    chirq_en_cmd #(.NUM_CH(NCH), .ADDR_W(AW)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_be   (bus_be),
        .bus_rdata(bus_rdata),
        .irq_en   (irq_en)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [NCH-1:0] cmd_mask(logic [7:0] b);
        if (b[7]) return '0;
        if (b[6]) return '1;
        if (int'(b[3:0]) < NCH) return NCH'(1) << b[3:0];
        return '0;
    endfunction

    function automatic void model_write(logic [AW-1:0] a, logic [31:0] d, logic [3:0] be);
        logic [15:0] f;
        logic [NCH-1:0] sm, cm;
        if (a == 0) begin
            f = 16'(model);
            if (be[0]) f[7:0]  = d[7:0];
            if (be[1]) f[15:8] = d[15:8];
            model = f[NCH-1:0];
        end else if (a == 1) begin
            sm = be[2] ? cmd_mask(d[23:16]) : '0;
            cm = be[3] ? cmd_mask(d[31:24]) : '0;
            model = (model | sm) & ~cm;
        end
    endfunction

    task automatic wr(logic [AW-1:0] a, logic [31:0] d, logic [3:0] be);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
        @(negedge clk);
        bus_wr = 1'b0; bus_be = '0;
        model_write(a, d, be);
    endtask

    task automatic check_state(string req);
        bus_addr = 0;
        #1;
        check(req, 32'(irq_en), 32'(model));
        check(req, bus_rdata, 32'(model));
    endtask

    function automatic string label(logic [7:0] b, string base);
        if (b[7]) return "R4";
        if (b[6]) return "R5";
        if (b[5:4] != 0) return "R6";
        if (int'(b[3:0]) >= NCH) return "R11";
        return base;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] lcg;
        rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; bus_be = '0;
        model = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        check_state("R1");

        // R2/R4/R5/R6/R11: every set byte from an all-zero state
        for (int v = 0; v < 256; v++) begin
            wr(0, 32'h0, 4'b0011);
            wr(1, {8'h80, 8'(v), 16'h0}, 4'b0100);
            check_state(label(8'(v), "R2"));
        end
        // R3/R4/R5/R6/R11: every clear byte from an all-ones state
        for (int v = 0; v < 256; v++) begin
            wr(0, 32'hFFFF, 4'b0011);
            wr(1, {8'(v), 8'h00, 16'h0}, 4'b1000);
            check_state(label(8'(v), "R3"));
        end
        // R8: set and clear of every channel pair in one word
        for (int s = 0; s < 16; s++) begin
            for (int c = 0; c < 16; c++) begin
                wr(0, 32'h0A5A, 4'b0011);
                wr(1, {8'(c), 8'(s), 16'hFFFF}, 4'b1111);
                check_state("R8");
            end
        end
        // R9/R10: direct writes under every byte-enable pattern
        for (int be = 0; be < 16; be++) begin
            wr(0, 32'h0, 4'b0011);
            wr(0, 32'hDEAD_B7C3, 4'(be));
            check_state("R9");
        end
        // R10: command lanes ignored without their byte enables
        wr(0, 32'h0, 4'b0011);
        wr(1, 32'h4040_4040, 4'b0011);
        check_state("R10");
        // R7: command word reads zero
        wr(0, 32'hFFFF, 4'b0011);
        bus_addr = 1; #1;
        check("R7", bus_rdata, 32'h0);
        // mixed sequence
        lcg = 32'h1234_5678;
        for (int i = 0; i < 400; i++) begin
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            wr((lcg[31:30] == 0) ? 4'd0 : 4'd1, lcg ^ {lcg[15:0], lcg[31:16]}, lcg[7:4]);
            check_state("R10");
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule